// File: doc/BRIEF.md
# Card Data FIFO Path with Interrupt and DMA Routing

This block is the byte data path of an MMC/SD host controller. A command sequencer (outside the block) pulses `cmd_start` together with the transfer direction, the DMA choice and the total byte count. In the read direction the block pulls bytes from the card's byte port into a 32-byte receive ring. Software or a DMA engine empties the ring through a 32-bit data register. In the write direction software fills a 32-byte transmit ring through the same kind of register, and the block then streams those bytes out to the card.

A remaining-byte counter decides when the transfer is finished. FIFO service requests and completion flags are collected in a 13-bit request vector. That vector passes through a mask register to a single interrupt line. When DMA mode is selected, the two FIFO service requests leave the interrupt path and drive their own DMA request lines instead.

Sequencing is a four-state machine. IDLE is left for RX_FILL or TX_COLLECT on `cmd_start`, according to direction. RX_FILL returns to IDLE when the count is exhausted. TX_COLLECT moves to TX_DRAIN on a drain trigger, or to IDLE when the count is zero. TX_DRAIN returns to TX_COLLECT when the ring runs empty with bytes still owed, or to IDLE when the count is exhausted. A `cmd_start` in any state restarts the machine.

Top module: `card_fifo_path`

## Requirements
- R1: After reset `int_req`, `irq`, both DMA request lines, both card enables, both status flags and `rxf_rdata` are all zero.
- R2: In RX_FILL one card byte is stored per cycle while the remaining count is nonzero and the receive ring holds fewer than 32 bytes. Each stored byte sets request bit 5.
- R3: A receive-register read pops the smaller of the access size and the bytes held. The access size `acc_size` is coded 00 for 1 byte, 01 for 2 bytes, and 10 or 11 for 4 bytes. The first byte popped lands in the most significant lane of the access, and lanes not filled read as zero. `rxf_rdata` is valid the cycle after `rxf_rd`.
- R4: A receive-register read clears request bit 5, unless a card byte is stored in the same cycle.
- R5: A transmit-register write pushes the access bytes from the most significant lane downward. Bytes that would take the ring beyond 32 are dropped.
- R6: TX_COLLECT enters TX_DRAIN when the ring is full, when the bytes held cover the remaining count, or when `tx_release` is pulsed with at least one byte held. TX_DRAIN sends one byte per cycle, in write order, to the card.
- R7: Request bit 6 is set in TX_COLLECT when the ring has room and holds fewer bytes than are still owed. A transmit-register write clears it.
- R8: When the remaining count reaches zero the machine goes to IDLE and sets request bit 0 and `stat_data_done`. A write transfer also sets request bit 1 and `stat_prg_done`. Both flags hold until the next `cmd_start`.
- R9: The mask register holds 13 bits, and a set bit suppresses the matching request. `irq` is high while any unmasked request bit is set.
- R10: With DMA mode latched, request bits 5 and 6 are excluded from `irq` and drive `rx_dma_req` and `tx_dma_req` directly.
- R11: `cmd_start` empties both rings, clears all request bits and both status flags, loads the remaining count, and latches direction and DMA mode.
- R12: `tx_release` with an empty transmit ring has no effect: no byte is sent and the machine stays in TX_COLLECT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Pulse: start a new transfer |
| cmd_wr_dir | input | 1 | Direction for the new transfer, 1 = write to card |
| cmd_dma | input | 1 | DMA mode for the new transfer |
| cmd_len | input | CNT_W | Total transfer length in bytes |
| acc_size | input | 2 | Register access size code |
| rxf_rd | input | 1 | Receive data register read strobe |
| rxf_rdata | output | 32 | Receive data register read value |
| txf_wr | input | 1 | Transmit data register write strobe |
| txf_wdata | input | 32 | Transmit data register write value |
| tx_release | input | 1 | Pulse: release a partly filled transmit ring |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 13 | Mask register write value |
| card_rd_en | output | 1 | Card byte taken this cycle |
| card_rd_data | input | 8 | Card byte presented to the block |
| card_wr_en | output | 1 | Card byte sent this cycle |
| card_wr_data | output | 8 | Byte sent to the card |
| int_req | output | 13 | Raw request vector |
| irq | output | 1 | Masked interrupt line |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| stat_data_done | output | 1 | Transfer finished |
| stat_prg_done | output | 1 | Write transfer finished |

## Verification
The assertions assume that `cmd_start` is a single-cycle pulse. They also assume that the card presents a valid byte on `card_rd_data` in every cycle that `card_rd_en` is high, and that no access size outside the coded set is used. The bench changes every input half a cycle away from the sampling edge. It pulses the strobes for exactly one cycle, and it models the card as a counter whose value is always present. Expected bytes therefore follow from that counter, and expected transmit bytes from the written words.

// File: rtl/card_fifo_pkg.sv
package card_fifo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_RX_FILL    = 2'd1,
        ST_TX_COLLECT = 2'd2,
        ST_TX_DRAIN   = 2'd3
    } xfer_state_e;

    localparam int REQ_W       = 13;
    localparam int RQ_DATA_END = 0;
    localparam int RQ_PRG_END  = 1;
    localparam int RQ_RX_SVC   = 5;
    localparam int RQ_TX_SVC   = 6;

    function automatic logic [2:0] access_bytes(input logic [1:0] code);
        case (code)
            2'b00:   access_bytes = 3'd1;
            2'b01:   access_bytes = 3'd2;
            default: access_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/card_byte_ring.sv
module card_byte_ring #(
    parameter int DEPTH       = 32,
    parameter int PUSH_LANES  = 1,
    parameter int POP_LANES   = 4,
    localparam int PW         = $clog2(DEPTH),
    localparam int CW         = PW + 1,
    localparam int PLW        = $clog2(PUSH_LANES) + 1,
    localparam int QLW        = $clog2(POP_LANES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [PLW-1:0]          push_n,
    input  logic [8*PUSH_LANES-1:0] push_bytes,
    input  logic [QLW-1:0]          pop_n,
    output logic [8*POP_LANES-1:0]  head_bytes,
    output logic [CW-1:0]           level
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        for (int k = 0; k < PUSH_LANES; k++) begin
            if (PLW'(k) < push_n) begin
                mem[wr_ptr + PW'(k)] <= push_bytes[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(push_n);
            rd_ptr <= rd_ptr + PW'(pop_n);
            level  <= level + CW'(push_n) - CW'(pop_n);
        end
    end

    for (genvar g = 0; g < POP_LANES; g++) begin : g_head
        assign head_bytes[8*g +: 8] = mem[rd_ptr + PW'(g)];
    end

endmodule

// File: rtl/card_xfer_ctrl.sv
module card_xfer_ctrl
    import card_fifo_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 28,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_wr_dir,
    input  logic             cmd_dma,
    input  logic [CNT_W-1:0] cmd_len,
    input  logic [CW-1:0]    rx_level,
    input  logic [CW-1:0]    tx_level,
    input  logic             rx_rd,
    input  logic             tx_wr,
    input  logic             tx_release,
    output logic             card_rd_en,
    output logic             card_wr_en,
    output logic [REQ_W-1:0] int_req,
    output logic             stat_data_done,
    output logic             stat_prg_done,
    output logic             dma_on
);

    xfer_state_e      state_q, state_d;
    logic [CNT_W-1:0] rem_q;
    logic             wr_dir_q;
    logic             rx_svc_q, tx_svc_q;
    logic             moved, finish, go_drain;

    always_comb begin
        card_rd_en = (state_q == ST_RX_FILL) && (rem_q != '0) && (rx_level < CW'(DEPTH));
        card_wr_en = (state_q == ST_TX_DRAIN) && (rem_q != '0) && (tx_level != '0);
        moved      = card_rd_en || card_wr_en;
        finish     = (state_q != ST_IDLE) &&
                     ((rem_q == '0) || (moved && rem_q == CNT_W'(1)));
        go_drain   = (state_q == ST_TX_COLLECT) && (tx_level != '0) &&
                     ((tx_level == CW'(DEPTH)) || (CNT_W'(tx_level) >= rem_q) || tx_release);
    end

    always_comb begin
        state_d = state_q;
        if (cmd_start) begin
            state_d = cmd_wr_dir ? ST_TX_COLLECT : ST_RX_FILL;
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_IDLE;
                ST_RX_FILL:    state_d = finish ? ST_IDLE : ST_RX_FILL;
                ST_TX_COLLECT: state_d = finish ? ST_IDLE :
                                         (go_drain ? ST_TX_DRAIN : ST_TX_COLLECT);
                ST_TX_DRAIN:   state_d = finish ? ST_IDLE :
                                         ((tx_level == '0) ? ST_TX_COLLECT : ST_TX_DRAIN);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q          <= '0;
            wr_dir_q       <= 1'b0;
            dma_on         <= 1'b0;
            rx_svc_q       <= 1'b0;
            tx_svc_q       <= 1'b0;
            stat_data_done <= 1'b0;
            stat_prg_done  <= 1'b0;
        end else if (cmd_start) begin
            rem_q          <= cmd_len;
            wr_dir_q       <= cmd_wr_dir;
            dma_on         <= cmd_dma;
            rx_svc_q       <= 1'b0;
            tx_svc_q       <= 1'b0;
            stat_data_done <= 1'b0;
            stat_prg_done  <= 1'b0;
        end else begin
            if (moved) rem_q <= rem_q - CNT_W'(1);
            if (card_rd_en)  rx_svc_q <= 1'b1;
            else if (rx_rd)  rx_svc_q <= 1'b0;
            if (tx_wr || finish) begin
                tx_svc_q <= 1'b0;
            end else if ((state_q == ST_TX_COLLECT) && (tx_level < CW'(DEPTH)) &&
                         (CNT_W'(tx_level) < rem_q)) begin
                tx_svc_q <= 1'b1;
            end
            if (finish) begin
                stat_data_done <= 1'b1;
                if (wr_dir_q) stat_prg_done <= 1'b1;
            end
        end
    end

    always_comb begin
        int_req              = '0;
        int_req[RQ_DATA_END] = stat_data_done;
        int_req[RQ_PRG_END]  = stat_prg_done;
        int_req[RQ_RX_SVC]   = rx_svc_q;
        int_req[RQ_TX_SVC]   = tx_svc_q;
    end

endmodule

// File: rtl/card_irq_route.sv
module card_irq_route
    import card_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic [REQ_W-1:0] mask_wdata,
    input  logic [REQ_W-1:0] int_req,
    input  logic             dma_on,
    output logic             irq,
    output logic             rx_dma_req,
    output logic             tx_dma_req
);

    logic [REQ_W-1:0] mask_q;
    logic [REQ_W-1:0] eff_mask;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    always_comb begin
        eff_mask = mask_q;
        if (dma_on) begin
            eff_mask[RQ_RX_SVC] = 1'b1;
            eff_mask[RQ_TX_SVC] = 1'b1;
        end
        irq        = |(int_req & ~eff_mask);
        rx_dma_req = dma_on && int_req[RQ_RX_SVC];
        tx_dma_req = dma_on && int_req[RQ_TX_SVC];
    end

endmodule

// File: rtl/card_fifo_path.sv
module card_fifo_path
    import card_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 28,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_wr_dir,
    input  logic             cmd_dma,
    input  logic [CNT_W-1:0] cmd_len,
    input  logic [1:0]       acc_size,
    input  logic             rxf_rd,
    output logic [31:0]      rxf_rdata,
    input  logic             txf_wr,
    input  logic [31:0]      txf_wdata,
    input  logic             tx_release,
    input  logic             mask_wr,
    input  logic [12:0]      mask_wdata,
    output logic             card_rd_en,
    input  logic [7:0]       card_rd_data,
    output logic             card_wr_en,
    output logic [7:0]       card_wr_data,
    output logic [12:0]      int_req,
    output logic             irq,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic             stat_data_done,
    output logic             stat_prg_done
);

    logic [2:0]    sz;
    logic [CW-1:0] rx_level, tx_level, tx_free;
    logic [2:0]    rx_pop_n, tx_push_n;
    logic [31:0]   rx_head, rd_word, tx_bytes;
    logic          dma_on;

    always_comb begin
        sz       = access_bytes(acc_size);
        tx_free  = CW'(DEPTH) - tx_level;
        rx_pop_n = '0;
        if (rxf_rd) rx_pop_n = (rx_level >= CW'(sz)) ? sz : rx_level[2:0];
        tx_push_n = '0;
        if (txf_wr) tx_push_n = (tx_free >= CW'(sz)) ? sz : tx_free[2:0];
    end

    always_comb begin
        logic [1:0] lane;
        rd_word  = '0;
        tx_bytes = '0;
        for (int k = 0; k < 4; k++) begin
            lane = 2'(int'(sz) - 1 - k);
            if (3'(k) < rx_pop_n) rd_word[8*lane +: 8] = rx_head[8*k +: 8];
            if (3'(k) < sz)       tx_bytes[8*k +: 8] = txf_wdata[8*lane +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rxf_rdata <= '0;
        else if (rxf_rd) rxf_rdata <= rd_word;
    end

    card_byte_ring #(.DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(4)) u_rx_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cmd_start),
        .push_n     (card_rd_en),
        .push_bytes (card_rd_data),
        .pop_n      (rx_pop_n),
        .head_bytes (rx_head),
        .level      (rx_level)
    );

    card_byte_ring #(.DEPTH(DEPTH), .PUSH_LANES(4), .POP_LANES(1)) u_tx_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cmd_start),
        .push_n     (tx_push_n),
        .push_bytes (tx_bytes),
        .pop_n      (card_wr_en),
        .head_bytes (card_wr_data),
        .level      (tx_level)
    );

    card_xfer_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_start      (cmd_start),
        .cmd_wr_dir     (cmd_wr_dir),
        .cmd_dma        (cmd_dma),
        .cmd_len        (cmd_len),
        .rx_level       (rx_level),
        .tx_level       (tx_level),
        .rx_rd          (rxf_rd),
        .tx_wr          (txf_wr),
        .tx_release     (tx_release),
        .card_rd_en     (card_rd_en),
        .card_wr_en     (card_wr_en),
        .int_req        (int_req),
        .stat_data_done (stat_data_done),
        .stat_prg_done  (stat_prg_done),
        .dma_on         (dma_on)
    );

    card_irq_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .int_req    (int_req),
        .dma_on     (dma_on),
        .irq        (irq),
        .rx_dma_req (rx_dma_req),
        .tx_dma_req (tx_dma_req)
    );

endmodule

// File: rtl/card_fifo_chk.sv
module card_fifo_chk #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_start,
    input logic          card_rd_en,
    input logic          card_wr_en,
    input logic [CW-1:0] rx_level,
    input logic [CW-1:0] tx_level,
    input logic [12:0]   int_req,
    input logic          rx_dma_req,
    input logic          stat_data_done,
    input logic          stat_prg_done
);

    // R2
    rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_rd_en |-> (rx_level < CW'(DEPTH)));

    // R2
    rx_req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rd_en && !cmd_start) |=> int_req[5]);

    // R5
    tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= CW'(DEPTH));

    // R6
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_rd_en && card_wr_en));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_data_done && !cmd_start) |=> stat_data_done);

    // R8
    prg_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_prg_done |-> stat_data_done);

    // R10
    rx_dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> int_req[5]);

endmodule

bind card_fifo_path card_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_start      (cmd_start),
    .card_rd_en     (card_rd_en),
    .card_wr_en     (card_wr_en),
    .rx_level       (rx_level),
    .tx_level       (tx_level),
    .int_req        (int_req),
    .rx_dma_req     (rx_dma_req),
    .stat_data_done (stat_data_done),
    .stat_prg_done  (stat_prg_done)
);

// File: tb/card_fifo_path_tb.sv
module card_fifo_path_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0, cmd_wr_dir = 1'b0, cmd_dma = 1'b0;
    logic [27:0] cmd_len = '0;
    logic [1:0]  acc_size = 2'b10;
    logic        rxf_rd = 1'b0, txf_wr = 1'b0, tx_release = 1'b0, mask_wr = 1'b0;
    logic [31:0] rxf_rdata, txf_wdata = '0;
    logic [12:0] mask_wdata = '0, int_req;
    logic        card_rd_en, card_wr_en, irq, rx_dma_req, tx_dma_req;
    logic        stat_data_done, stat_prg_done;
    logic [7:0]  card_rd_data, card_wr_data;

    int n_vec = 0, n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] rd_idx;
    logic [7:0] cap [64];
    int         cap_n;

    always #4 clk = ~clk;

    assign card_rd_data = rd_idx ^ 8'hA5;

    always @(posedge clk) begin
        if (!rst_n) rd_idx <= 8'd0;
        else if (card_rd_en) rd_idx <= rd_idx + 8'd1;
    end

    always @(posedge clk) begin
        if (!rst_n) cap_n <= 0;
        else if (card_wr_en) begin
            cap[cap_n[5:0]] <= card_wr_data;
            cap_n <= cap_n + 1;
        end
    end

    card_fifo_path u_dut (.*);

    function automatic logic [7:0] rxb(input logic [7:0] base, input int i);
        return (base + 8'(i)) ^ 8'hA5;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cmd(input logic wr, input logic dma, input int len);
        cmd_start = 1'b1; cmd_wr_dir = wr; cmd_dma = dma; cmd_len = 28'(len);
        tick(1);
        cmd_start = 1'b0;
    endtask

    task automatic rx_read(input logic [1:0] s, output logic [31:0] d);
        acc_size = s; rxf_rd = 1'b1;
        tick(1);
        rxf_rd = 1'b0;
        d = rxf_rdata;
    endtask

    task automatic tx_write(input logic [1:0] s, input logic [31:0] d);
        acc_size = s; txf_wdata = d; txf_wr = 1'b1;
        tick(1);
        txf_wr = 1'b0;
    endtask

    task automatic release_tx();
        tx_release = 1'b1;
        tick(1);
        tx_release = 1'b0;
    endtask

    task automatic set_mask(input logic [12:0] m);
        mask_wdata = m; mask_wr = 1'b1;
        tick(1);
        mask_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 int_req", 32'(int_req), 32'h0);
        chk("R1 irq/dma", {29'd0, irq, rx_dma_req, tx_dma_req}, 32'h0);
        chk("R1 card enables", {30'd0, card_rd_en, card_wr_en}, 32'h0);
        chk("R1 status", {30'd0, stat_data_done, stat_prg_done}, 32'h0);
        chk("R1 rdata", rxf_rdata, 32'h0);
    endtask

    task automatic t_rx_basic();
        logic [7:0]  b;
        logic [31:0] d;
        b = rd_idx;
        start_cmd(1'b0, 1'b0, 8);
        tick(12);
        chk("R8 rx done", {30'd0, stat_data_done, stat_prg_done}, 32'h2);
        chk("R2 rx request", 32'(int_req), 32'h21);
        chk("R9 irq", 32'(irq), 32'h1);
        rx_read(2'b10, d);
        chk("R3 four-byte pack", d, {rxb(b,0), rxb(b,1), rxb(b,2), rxb(b,3)});
        chk("R4 rx request cleared", 32'(int_req[5]), 32'h0);
        rx_read(2'b01, d);
        chk("R3 two-byte pack", d, {16'd0, rxb(b,4), rxb(b,5)});
        rx_read(2'b00, d);
        chk("R3 one-byte pack", d, {24'd0, rxb(b,6)});
        rx_read(2'b11, d);
        chk("R3 short pop top lane", d, {rxb(b,7), 24'd0});
        rx_read(2'b10, d);
        chk("R3 empty read", d, 32'h0);
    endtask

    task automatic t_rx_full();
        logic [7:0]  b;
        logic [31:0] d;
        b = rd_idx;
        start_cmd(1'b0, 1'b0, 40);
        tick(40);
        chk("R2 fill stops at 32", 32'(card_rd_en), 32'h0);
        chk("R2 not done", 32'(stat_data_done), 32'h0);
        rx_read(2'b10, d);
        chk("R3 first word", d, {rxb(b,0), rxb(b,1), rxb(b,2), rxb(b,3)});
        tick(6);
        for (int j = 1; j < 10; j++) begin
            rx_read(2'b10, d);
            chk("R2 stream order", d,
                {rxb(b,4*j), rxb(b,4*j+1), rxb(b,4*j+2), rxb(b,4*j+3)});
        end
        chk("R8 done after 40", 32'(stat_data_done), 32'h1);
    endtask

    task automatic t_mask_dma();
        set_mask(13'h0020);
        start_cmd(1'b0, 1'b0, 40);
        tick(3);
        chk("R9 masked request", {30'd0, int_req[5], irq}, 32'h2);
        set_mask(13'h0000);
        chk("R9 unmasked request", 32'(irq), 32'h1);
        start_cmd(1'b0, 1'b1, 40);
        tick(3);
        chk("R10 rx dma routing", {29'd0, irq, rx_dma_req, int_req[5]}, 32'h3);
        start_cmd(1'b1, 1'b1, 8);
        tick(3);
        chk("R10 tx dma routing", {29'd0, irq, tx_dma_req, int_req[6]}, 32'h3);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        start_cmd(1'b0, 1'b0, 40);
        tick(5);
        start_cmd(1'b1, 1'b0, 8);
        chk("R11 requests cleared", 32'(int_req), 32'h0);
        rx_read(2'b10, d);
        chk("R11 rx ring emptied", d, 32'h0);
    endtask

    task automatic t_tx_basic();
        int c0;
        start_cmd(1'b1, 1'b0, 8);
        c0 = cap_n;
        tick(1);
        chk("R7 tx request set", 32'(int_req[6]), 32'h1);
        tx_write(2'b10, 32'h11223344);
        chk("R7 tx request cleared", 32'(int_req[6]), 32'h0);
        tick(3);
        chk("R6 no early drain", 32'(cap_n - c0), 32'h0);
        tx_write(2'b10, 32'h55667788);
        tick(12);
        chk("R6 drained count", 32'(cap_n - c0), 32'h8);
        for (int i = 0; i < 8; i++)
            chk("R5 tx byte order", 32'(cap[(c0+i) % 64]), 32'(8'h11 * (i + 1)));
        chk("R8 write done", {30'd0, stat_data_done, stat_prg_done}, 32'h3);
        chk("R8 request bits", 32'(int_req[1:0]), 32'h3);
    endtask

    task automatic t_tx_release();
        int c0;
        start_cmd(1'b1, 1'b0, 10);
        c0 = cap_n;
        release_tx();
        tick(2);
        chk("R12 empty release", 32'(cap_n - c0), 32'h0);
        tx_write(2'b01, 32'h0000BEEF);
        tick(2);
        chk("R6 held below trigger", 32'(cap_n - c0), 32'h0);
        release_tx();
        tick(4);
        chk("R6 release drains", 32'(cap_n - c0), 32'h2);
        chk("R5 two-byte order", {16'd0, cap[c0 % 64], cap[(c0+1) % 64]}, 32'h0000BEEF);
        chk("R8 not yet done", 32'(stat_data_done), 32'h0);
        tx_write(2'b10, 32'h01020304);
        tx_write(2'b10, 32'h05060708);
        tick(12);
        chk("R8 release transfer done", {30'd0, stat_data_done, stat_prg_done}, 32'h3);
        chk("R6 release total", 32'(cap_n - c0), 32'd10);
    endtask

    task automatic t_tx_overflow();
        int c0;
        start_cmd(1'b1, 1'b0, 40);
        c0 = cap_n;
        for (int w = 0; w < 8; w++)
            tx_write(2'b10, {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)});
        tx_write(2'b10, 32'hEEEEEEEE);
        tick(40);
        chk("R5 full ring drained", 32'(cap_n - c0), 32'd32);
        for (int i = 0; i < 32; i++)
            chk("R5 overflow dropped", 32'(cap[(c0+i) % 64]), i);
        tx_write(2'b10, 32'h20212223);
        tx_write(2'b10, 32'h24252627);
        tick(12);
        chk("R8 long write done", 32'(stat_data_done), 32'h1);
        for (int i = 32; i < 40; i++)
            chk("R5 tail bytes", 32'(cap[(c0+i) % 64]), i);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_rx_basic();
        t_rx_full();
        t_mask_dma();
        t_restart();
        t_tx_basic();
        t_tx_release();
        t_tx_overflow();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule